// File: doc/BRIEF.md
# Round-Key Generator for a 16-Round Feistel Cipher

This block sits next to an iterative 64-bit Feistel cipher core. It produces the core's 48-bit round keys one per clock. A load strobe captures a 64-bit key and a direction bit. Each advance pulse then moves the generator to the next round, in step with the core's round counter.

The block first drops the eight parity bits of the key, leaving 56 bits. It splits them into two 28-bit halves and rotates both halves by one or two places per round, following a fixed schedule. The rotated halves are then compressed to 48 bits.

In the decrypt direction the same halves walk backwards with right rotations, so the keys appear in reverse order. The last key comes straight from the unrotated halves, because a full schedule turns each half by 28 places, which is one complete revolution. The key and the round number leave the block from registers.

Top module: `rkey_gen`

## Requirements
- R1: After reset `rkey_o` is 0, `round_o` is 0 and `valid_o` is 0.
- R2: A cycle with `load_i` high sets `round_o` to 1 and `valid_o` to 1 on the next edge. In encrypt mode (`dec_i`=0) `rkey_o` then holds the first round key. For key 0x133457799BBCDFF1 that key is 0x1B02EFFC7072.
- R3: In encrypt mode, each `adv_i` cycle while `round_o` is below 16 raises `round_o` by one. On the same edge `rkey_o` changes to the key of that round. All 16 keys match the reference schedule.
- R4: Both halves rotate left by 1 place for rounds 1, 2, 9 and 16, and by 2 places for every other round. Rotation amounts accumulate from round to round.
- R5: In decrypt mode (`dec_i`=1 at load), step s delivers the key of round 17-s. The first key delivered is round 16's key, which for key 0x133457799BBCDFF1 is 0xCB3D8B0E17F5.
- R6: `adv_i` while `round_o` is 16 has no effect: `rkey_o` and `round_o` hold.
- R7: With neither `load_i` nor `adv_i` high, `rkey_o` and `round_o` hold.
- R8: `load_i` takes priority over `adv_i` and restarts the sequence at round 1 from the new key at any point.
- R9: Key bits 0, 8, 16, ..., 56 (the least significant bit of each byte) are parity bits and do not affect any round key.
- R10: The direction is captured only at load. Changing `dec_i` mid-sequence does not alter the keys delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 64 | Cipher key, parity bits included |
| load_i | input | 1 | Capture key and direction, start at round 1 |
| dec_i | input | 1 | Direction at load: 0 encrypt, 1 decrypt |
| adv_i | input | 1 | Step to the next round |
| rkey_o | output | 48 | Current round key |
| round_o | output | 5 | Current step number 1..16, 0 before first load |
| valid_o | output | 1 | A key has been loaded since reset |

## Verification
A wrong rotation amount in any single round corrupts that round's key and every later key. This is seen at `rkey_o` on the very edge of the faulty advance. Comparing every one of the 16 keys against a model therefore locates a schedule error to one cycle.

A decrypt walk that rotates the wrong way, or by the wrong schedule entry, fails by step 2 at the latest. A compression or parity-drop error shows on the first key after load.

// File: rtl/rkey_pkg.sv
package rkey_pkg;
  localparam int KEY_W  = 64;
  localparam int SEL_W  = 56;
  localparam int HALF_W = 28;
  localparam int RK_W   = 48;
  localparam int ROUNDS = 16;
  localparam int RND_W  = $clog2(ROUNDS + 1);

  // 1-based source positions, position 1 = most significant bit
  localparam logic [6:0] DROP_SEL [SEL_W] = '{
    7'd57, 7'd49, 7'd41, 7'd33, 7'd25, 7'd17, 7'd9,  7'd1,
    7'd58, 7'd50, 7'd42, 7'd34, 7'd26, 7'd18, 7'd10, 7'd2,
    7'd59, 7'd51, 7'd43, 7'd35, 7'd27, 7'd19, 7'd11, 7'd3,
    7'd60, 7'd52, 7'd44, 7'd36, 7'd63, 7'd55, 7'd47, 7'd39,
    7'd31, 7'd23, 7'd15, 7'd7,  7'd62, 7'd54, 7'd46, 7'd38,
    7'd30, 7'd22, 7'd14, 7'd6,  7'd61, 7'd53, 7'd45, 7'd37,
    7'd29, 7'd21, 7'd13, 7'd5,  7'd28, 7'd20, 7'd12, 7'd4};

  localparam logic [5:0] SQUEEZE_SEL [RK_W] = '{
    6'd14, 6'd17, 6'd11, 6'd24, 6'd1,  6'd5,  6'd3,  6'd28,
    6'd15, 6'd6,  6'd21, 6'd10, 6'd23, 6'd19, 6'd12, 6'd4,
    6'd26, 6'd8,  6'd16, 6'd7,  6'd27, 6'd20, 6'd13, 6'd2,
    6'd41, 6'd52, 6'd31, 6'd37, 6'd47, 6'd55, 6'd30, 6'd40,
    6'd51, 6'd45, 6'd33, 6'd48, 6'd44, 6'd49, 6'd39, 6'd56,
    6'd34, 6'd53, 6'd46, 6'd42, 6'd50, 6'd36, 6'd29, 6'd32};

  // one-place rounds: 1, 2, 9, 16
  function automatic logic double_step(input logic [RND_W-1:0] r);
    return !(r == 1 || r == 2 || r == 9 || r == 16);
  endfunction
endpackage

// File: rtl/rkey_select.sv
module rkey_select
  import rkey_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  output logic [HALF_W-1:0] c_o,
  output logic [HALF_W-1:0] d_o
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int j = 0; j < SEL_W; j++)
      sel[SEL_W-1-j] = key_i[KEY_W - int'(DROP_SEL[j])];
  end

  assign c_o = sel[SEL_W-1:HALF_W];
  assign d_o = sel[HALF_W-1:0];
endmodule

// File: rtl/rkey_rotate.sv
module rkey_rotate #(
  parameter int W = 28
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic         two,   // 0: one place, 1: two places
  input  logic         right, // 0: left, 1: right
  output logic [W-1:0] dout
);
  logic [W-1:0] l1, l2, r1, r2;

  assign l1 = {din[W-2:0], din[W-1]};
  assign l2 = {din[W-3:0], din[W-1:W-2]};
  assign r1 = {din[0], din[W-1:1]};
  assign r2 = {din[1:0], din[W-1:2]};

  always_comb begin
    if (!en)        dout = din;
    else if (right) dout = two ? r2 : r1;
    else            dout = two ? l2 : l1;
  end
endmodule

// File: rtl/rkey_squeeze.sv
module rkey_squeeze
  import rkey_pkg::*;
(
  input  logic [SEL_W-1:0] cd_i,
  output logic [RK_W-1:0]  rk_o
);
  always_comb begin
    rk_o = '0;
    for (int j = 0; j < RK_W; j++)
      rk_o[RK_W-1-j] = cd_i[SEL_W - int'(SQUEEZE_SEL[j])];
  end
endmodule

// File: rtl/rkey_gen.sv
module rkey_gen
  import rkey_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic              adv_i,
  output logic [RK_W-1:0]   rkey_o,
  output logic [RND_W-1:0]  round_o,
  output logic              valid_o
);
  logic [HALF_W-1:0] c_q, d_q, c_ld, d_ld;
  logic [HALF_W-1:0] half_src [2];
  logic [HALF_W-1:0] half_nxt [2];
  logic              dec_q;
  logic              step, rot_en, rot_two, rot_right;
  logic [RND_W-1:0]  sched_r;
  logic [RK_W-1:0]   rk_nxt;

  rkey_select u_sel (.key_i(key_i), .c_o(c_ld), .d_o(d_ld));

  assign step = adv_i && valid_o && (round_o < RND_W'(ROUNDS));

  // round whose shift is applied (encrypt) or undone (decrypt)
  always_comb begin
    if (load_i)     sched_r = RND_W'(1);
    else if (dec_q) sched_r = RND_W'(ROUNDS + 1) - round_o;
    else            sched_r = round_o + RND_W'(1);
  end

  assign half_src[0] = load_i ? c_ld : c_q;
  assign half_src[1] = load_i ? d_ld : d_q;
  assign rot_en    = load_i ? !dec_i : step;
  assign rot_two   = double_step(sched_r);
  assign rot_right = !load_i && dec_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    rkey_rotate #(.W(HALF_W)) u_rot (
      .din(half_src[h]), .en(rot_en), .two(rot_two),
      .right(rot_right), .dout(half_nxt[h]));
  end

  rkey_squeeze u_sq (.cd_i({half_nxt[0], half_nxt[1]}), .rk_o(rk_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q     <= '0;
      d_q     <= '0;
      dec_q   <= 1'b0;
      rkey_o  <= '0;
      round_o <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      c_q     <= half_nxt[0];
      d_q     <= half_nxt[1];
      dec_q   <= dec_i;
      rkey_o  <= rk_nxt;
      round_o <= RND_W'(1);
      valid_o <= 1'b1;
    end else if (step) begin
      c_q     <= half_nxt[0];
      d_q     <= half_nxt[1];
      rkey_o  <= rk_nxt;
      round_o <= round_o + RND_W'(1);
    end
  end

  // R2 load restarts at round 1
  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (round_o == RND_W'(1)) && valid_o);
  // R3 advance steps the round by one
  a_r3_adv_step: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv_i && !load_i && round_o < RND_W'(ROUNDS))
      |=> round_o == $past(round_o) + RND_W'(1));
  // R6 advance at the last round is ignored
  a_r6_last_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv_i && !load_i && round_o == RND_W'(ROUNDS))
      |=> $stable(rkey_o) && $stable(round_o));
  // R7 outputs hold while idle
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> $stable(rkey_o) && $stable(round_o));
  // R3 round stays within 1..16 once loaded
  a_r3_round_range: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (round_o >= RND_W'(1)) && (round_o <= RND_W'(ROUNDS)));
endmodule

// File: tb/rkey_gen_tb.sv
module rkey_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] key_i;
  logic        load_i, dec_i, adv_i;
  logic [47:0] rkey_o;
  logic [4:0]  round_o;
  logic        valid_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rkey_gen u_dut (.clk(clk), .rst(rst), .key_i(key_i), .load_i(load_i),
    .dec_i(dec_i), .adv_i(adv_i), .rkey_o(rkey_o), .round_o(round_o),
    .valid_o(valid_o));

  localparam int M_PC1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,19,11,3,60,52,44,36,63,55,47,39,31,23,15,7,62,54,
    46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int M_PC2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,
    4,26,8,16,7,27,20,13,2,41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,
    56,34,53,46,42,50,36,29,32};

  // reference: key of round n (1..16) built from scratch
  function automatic logic [47:0] model_key(input logic [63:0] k, input int n);
    logic [55:0] s;
    logic [27:0] c, d;
    logic [47:0] r;
    int amt;
    for (int j = 0; j < 56; j++) s[55-j] = k[64-M_PC1[j]];
    c = s[55:28]; d = s[27:0];
    amt = 0;
    for (int r0 = 1; r0 <= n; r0++)
      amt += (r0 == 1 || r0 == 2 || r0 == 9 || r0 == 16) ? 1 : 2;
    for (int a = 0; a < amt; a++) begin
      c = {c[26:0], c[27]};
      d = {d[26:0], d[27]};
    end
    s = {c, d};
    for (int j = 0; j < 48; j++) r[47-j] = s[56-M_PC2[j]];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] k, input logic d);
    @(negedge clk); key_i = k; dec_i = d; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_adv();
    @(negedge clk); adv_i = 1'b1;
    @(negedge clk); adv_i = 1'b0;
  endtask

  localparam logic [63:0] K0 = 64'h133457799BBCDFF1;

  task automatic t_reset();
    chk("R1 key", 64'(rkey_o), 64'h0);
    chk("R1 round", 64'(round_o), 64'h0);
    chk("R1 valid", 64'(valid_o), 64'h0);
  endtask

  task automatic t_encrypt(input logic [63:0] k);
    do_load(k, 1'b0);
    chk("R2 round", 64'(round_o), 64'd1);
    chk("R2 valid", 64'(valid_o), 64'd1);
    chk("R2 first key", 64'(rkey_o), 64'(model_key(k, 1)));
    for (int s = 2; s <= 16; s++) begin
      do_adv();
      chk("R3 round", 64'(round_o), 64'(s));
      chk("R3 R4 key", 64'(rkey_o), 64'(model_key(k, s)));
    end
  endtask

  task automatic t_vectors();
    do_load(K0, 1'b0);
    chk("R2 vector", 64'(rkey_o), 64'h1B02EFFC7072);
    do_load(K0, 1'b1);
    chk("R5 vector", 64'(rkey_o), 64'hCB3D8B0E17F5);
  endtask

  task automatic t_decrypt(input logic [63:0] k);
    do_load(k, 1'b1);
    chk("R5 round", 64'(round_o), 64'd1);
    chk("R5 key", 64'(rkey_o), 64'(model_key(k, 16)));
    for (int s = 2; s <= 16; s++) begin
      do_adv();
      chk("R5 round", 64'(round_o), 64'(s));
      chk("R5 key", 64'(rkey_o), 64'(model_key(k, 17 - s)));
    end
  endtask

  task automatic t_last_hold();
    logic [47:0] kept;
    kept = rkey_o;
    do_adv();
    chk("R6 key", 64'(rkey_o), 64'(kept));
    chk("R6 round", 64'(round_o), 64'd16);
  endtask

  task automatic t_idle();
    do_load(K0, 1'b0);
    do_adv();
    repeat (4) @(negedge clk);
    chk("R7 key", 64'(rkey_o), 64'(model_key(K0, 2)));
    chk("R7 round", 64'(round_o), 64'd2);
  endtask

  task automatic t_restart();
    logic [63:0] k2;
    k2 = 64'h0E329232EA6D0D73;
    do_load(K0, 1'b0);
    do_adv(); do_adv(); do_adv();
    @(negedge clk); key_i = k2; dec_i = 1'b0; load_i = 1'b1; adv_i = 1'b1;
    @(negedge clk); load_i = 1'b0; adv_i = 1'b0;
    chk("R8 round", 64'(round_o), 64'd1);
    chk("R8 key", 64'(rkey_o), 64'(model_key(k2, 1)));
  endtask

  task automatic t_parity();
    logic [63:0] kp;
    kp = K0 ^ 64'h0101010101010101;
    do_load(kp, 1'b0);
    chk("R9 first", 64'(rkey_o), 64'h1B02EFFC7072);
    do_load(kp, 1'b1);
    chk("R9 last", 64'(rkey_o), 64'hCB3D8B0E17F5);
  endtask

  task automatic t_dir_latch();
    do_load(K0, 1'b0);
    @(negedge clk); dec_i = 1'b1;
    do_adv(); do_adv();
    chk("R10 enc", 64'(rkey_o), 64'(model_key(K0, 3)));
    do_load(K0, 1'b1);
    @(negedge clk); dec_i = 1'b0;
    do_adv();
    chk("R10 dec", 64'(rkey_o), 64'(model_key(K0, 15)));
  endtask

  initial begin
    fork
      begin
        rst = 1'b1; key_i = '0; load_i = 1'b0; dec_i = 1'b0; adv_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vectors();
        t_encrypt(K0);
        t_last_hold();
        t_encrypt(64'hA5C3_0F1E_7788_9911);
        t_decrypt(K0);
        t_last_hold();
        t_decrypt(64'hFEDC_BA98_7654_3210);
        t_idle();
        t_restart();
        t_parity();
        t_dir_latch();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule